// File: doc/BRIEF.md
# Transmit Length and Payload Feeder

This block sits between a host register port and a bit-level frame encoder. The host writes a frame length into two registers and then payload bytes into a twelve-entry FIFO. It uses one register address per write, or a burst whose address steps forward on its own. The first payload byte starts the frame without any separate command. Bytes then leave towards the serializer over a ready/valid handshake. A down-counter marks the final byte as end-of-frame, and that final byte may carry a partial bit count.

The block keeps four event flags in one status register, which the host reads. An interrupt line is high while the completion, refill or underrun flag is set. A refill request is raised only for longer frames, when the FIFO drains to three bytes. If the serializer asks for a byte while the FIFO is empty, the frame is aborted and no end-of-frame is requested.

Top module: `tx_frame_feeder`

## Requirements
- R1: A write with `wr_burst_start` high goes to `wr_addr`. Every later write without it goes to the address after the previous one, and the address stops advancing once it reaches 0x1F. Writes that land outside 0x1D–0x1F have no effect.
- R2: Frame length in bytes = count + P. The count is 12 bits: 0x1D[7:0] are count[11:4] and 0x1E[7:4] are count[3:0]. P is 0x1E[0], the partial-byte-present bit, and 0x1E[3:1] give the bit count of that partial final byte.
- R3: The FIFO holds 12 bytes. A payload write while it is full is dropped, and the dropped byte is never sent.
- R4: While idle, a write to 0x1F with a nonzero frame length starts the frame and sets status bit 7. While idle with a zero length, writes to 0x1F are ignored. Writes to 0x1D and 0x1E are ignored while a frame is active.
- R5: `out_valid` is high while a frame is active and the FIFO is not empty. While `out_ready` is low, `out_valid` and `out_data` hold steady. Bytes leave in the order they were written.
- R6: `out_last` is high with the final byte of the frame only. On that byte, `out_partial` equals P and `out_pbits` equals 0x1E[3:1] when P is 1, and is 0 otherwise.
- R7: When the final byte is accepted, status bit 6 (done) is set, the frame ends, and any bytes left in the FIFO are discarded.
- R8: When a transfer without a write in the same cycle takes the FIFO level from 4 to 3, status bit 5 (refill) is set, but only if the frame length is 5 or more. Frames of 4 bytes or fewer raise the interrupt only at completion.
- R9: If `out_ready` is high while a frame is active and the FIFO is empty, status bit 4 (underrun) is set. The frame is then aborted without `out_last`.
- R10: `sts_data` shows the flags in bits 7:4, with bits 3:0 zero. A cycle with `sts_rd` high clears all flags. `irq` is the OR of bits 6, 5 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_burst_start | input | 1 | Take address from `wr_addr` for this write |
| wr_addr | input | 8 | Write address at burst start |
| wr_data | input | 8 | Write data |
| sts_rd | input | 1 | Status read, clears the flags |
| sts_data | output | 8 | Status flags |
| irq | output | 1 | Interrupt request |
| out_valid | output | 1 | Byte available to serializer |
| out_ready | input | 1 | Serializer accepts byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Final byte, request end-of-frame |
| out_partial | output | 1 | Final byte is partial |
| out_pbits | output | 3 | Bit count of partial final byte |

## Verification
The assertions rely on the host not rewriting the length registers between a refill event and the next cycle. They also rely on `sts_rd` and payload writes being ordinary single-cycle pulses. The bench holds `out_ready` low while it loads each frame, except in the deliberate underrun case, so an empty FIFO is never met by a ready serializer by accident. It drives the length only in bursts issued while the block is idle, apart from one burst sent during an active frame to show that the lock holds.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 12;
  localparam logic [7:0] ADDR_LEN_HI = 8'h1D;
  localparam logic [7:0] ADDR_LEN_LO = 8'h1E;
  localparam logic [7:0] ADDR_DATA   = 8'h1F;
  // flag vector order inside the sequencer: {start, done, refill, underrun}
  localparam int FLG_START = 3;
  localparam int FLG_DONE  = 2;
  localparam int FLG_REFIL = 1;
  localparam int FLG_UNDER = 0;
endpackage

// File: rtl/txf_wr_port.sv
module txf_wr_port
  import txf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_burst_start,
  input  logic [7:0]        wr_addr,
  output logic              hi_we,
  output logic              lo_we,
  output logic              data_we
);
  logic [7:0] ptr_q, ptr_d, eff_addr;
  logic       ptr_en;

  always_comb begin
    eff_addr = wr_burst_start ? wr_addr : ptr_q;
    ptr_en   = wr_en;
    ptr_d    = (eff_addr == ADDR_DATA) ? ADDR_DATA : eff_addr + 8'd1;
    hi_we    = wr_en && (eff_addr == ADDR_LEN_HI);
    lo_we    = wr_en && (eff_addr == ADDR_LEN_LO);
    data_we  = wr_en && (eff_addr == ADDR_DATA);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/txf_fifo.sv
module txf_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 12,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    empty   = (lvl_q == '0);
    full    = (lvl_q == LW'(DEPTH));
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    wp_d    = push_ok ? bump(wp_q) : wp_q;
    rp_d    = pop_ok  ? bump(rp_q) : rp_q;
    lvl_d   = lvl_q + LW'(push_ok) - LW'(pop_ok);
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      lvl_d = '0;
    end
    head  = mem[rp_q];
    level = lvl_q;
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end
endmodule

// File: rtl/txf_seq.sv
module txf_seq
  import txf_pkg::*;
#(
  parameter int LW         = 4,
  parameter int REFILL_MIN = 5,
  parameter int LOW_MARK   = 3,
  localparam int TW        = CNT_W + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic          data_we,
  input  logic [7:0]    wr_data,
  input  logic          fifo_empty,
  input  logic [LW-1:0] fifo_level,
  input  logic          out_ready,
  input  logic          sts_rd,
  output logic          run,
  output logic          push,
  output logic          pop,
  output logic          flush,
  output logic          out_last,
  output logic          out_partial,
  output logic [2:0]    out_pbits,
  output logic [3:0]    flags,
  output logic [TW-1:0] frame_len
);
  logic [7:0]    len_hi_q, len_lo_q;
  logic          len_hi_en, len_lo_en;
  logic          run_q, run_d;
  logic [TW-1:0] remain_q, remain_d;
  logic          remain_en;
  logic [3:0]    flags_q, flags_d, flag_set;
  logic          start, fire, final_beat, underrun, refill_ev;

  always_comb begin
    frame_len  = {1'b0, len_hi_q, len_lo_q[7:4]} + TW'(len_lo_q[0]);
    len_hi_en  = hi_we && !run_q;
    len_lo_en  = lo_we && !run_q;
    start      = data_we && !run_q && (frame_len != '0);
    push       = data_we && (run_q || start);
    fire       = run_q && !fifo_empty && out_ready;
    final_beat = fire && (remain_q == TW'(1));
    underrun   = run_q && fifo_empty && out_ready;
    refill_ev  = fire && !push && (fifo_level == LW'(LOW_MARK + 1))
                 && (frame_len >= TW'(REFILL_MIN));
    pop        = fire;
    flush      = final_beat || underrun;

    run_d = run_q;
    if (start)                      run_d = 1'b1;
    else if (final_beat || underrun) run_d = 1'b0;

    remain_en = start || fire;
    remain_d  = start ? frame_len : remain_q - TW'(1);

    flag_set             = '0;
    flag_set[FLG_START]  = start;
    flag_set[FLG_DONE]   = final_beat;
    flag_set[FLG_REFIL]  = refill_ev;
    flag_set[FLG_UNDER]  = underrun;
    flags_d = (sts_rd ? 4'b0 : flags_q) | flag_set;

    run         = run_q;
    flags       = flags_q;
    out_last    = run_q && !fifo_empty && (remain_q == TW'(1));
    out_partial = out_last && len_lo_q[0];
    out_pbits   = out_partial ? len_lo_q[3:1] : 3'b000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_hi_q <= '0;
      len_lo_q <= '0;
      run_q    <= 1'b0;
      remain_q <= '0;
      flags_q  <= '0;
    end else begin
      if (len_hi_en) len_hi_q <= wr_data;
      if (len_lo_en) len_lo_q <= wr_data;
      if (remain_en) remain_q <= remain_d;
      run_q   <= run_d;
      flags_q <= flags_d;
    end
  end
endmodule

// File: rtl/tx_frame_feeder.sv
module tx_frame_feeder
  import txf_pkg::*;
#(
  parameter int FIFO_DEPTH = 12,
  parameter int REFILL_MIN = 5,
  parameter int LOW_MARK   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_burst_start,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       sts_rd,
  output logic [7:0] sts_data,
  output logic       irq,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       out_partial,
  output logic [2:0] out_pbits
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic          hi_we, lo_we, data_we;
  logic          run, push, pop, flush, fifo_empty, fifo_full;
  logic [LW-1:0] fifo_level;
  logic [3:0]    flags;
  logic [CNT_W:0] frame_len;

  txf_wr_port u_wr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_burst_start(wr_burst_start),
    .wr_addr(wr_addr), .hi_we(hi_we), .lo_we(lo_we), .data_we(data_we)
  );

  txf_fifo #(.DW(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wr_data), .pop(pop),
    .flush(flush), .head(out_data), .level(fifo_level), .empty(fifo_empty),
    .full(fifo_full)
  );

  txf_seq #(.LW(LW), .REFILL_MIN(REFILL_MIN), .LOW_MARK(LOW_MARK)) u_seq (
    .clk(clk), .rst_n(rst_n), .hi_we(hi_we), .lo_we(lo_we), .data_we(data_we),
    .wr_data(wr_data), .fifo_empty(fifo_empty), .fifo_level(fifo_level),
    .out_ready(out_ready), .sts_rd(sts_rd), .run(run), .push(push), .pop(pop),
    .flush(flush), .out_last(out_last), .out_partial(out_partial),
    .out_pbits(out_pbits), .flags(flags), .frame_len(frame_len)
  );

  always_comb begin
    sts_data  = {flags, 4'b0000};
    irq       = flags[FLG_DONE] | flags[FLG_REFIL] | flags[FLG_UNDER];
    out_valid = run && !fifo_empty;
  end
endmodule

// File: rtl/tx_frame_feeder_chk.sv
module tx_frame_feeder_chk #(
  parameter int DEPTH = 12,
  parameter int RMIN  = 5,
  parameter int LW    = 4,
  parameter int TW    = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          out_last,
  input logic          out_partial,
  input logic [7:0]    sts_data,
  input logic          run,
  input logic [LW-1:0] fifo_level,
  input logic [TW-1:0] frame_len
);
  assert_last_with_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_partial_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_partial |-> out_last);

  assert_hold_while_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_start_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> sts_data[7]);

  assert_refill_long_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_data[5]) |-> (frame_len >= TW'(RMIN)));

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));
endmodule

bind tx_frame_feeder tx_frame_feeder_chk #(
  .DEPTH(FIFO_DEPTH), .RMIN(REFILL_MIN), .LW(LW), .TW(txf_pkg::CNT_W + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last), .out_partial(out_partial),
  .sts_data(sts_data), .run(run), .fifo_level(fifo_level), .frame_len(frame_len)
);

// File: tb/tx_frame_feeder_tb.sv
module tx_frame_feeder_tb;
  logic       clk, rst_n;
  logic       wr_en, wr_burst_start, sts_rd, out_ready;
  logic [7:0] wr_addr, wr_data, sts_data, out_data;
  logic       irq, out_valid, out_last, out_partial;
  logic [2:0] out_pbits;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int bidx   = 0;
  logic seen_last = 0;

  tx_frame_feeder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_burst_start(wr_burst_start),
    .wr_addr(wr_addr), .wr_data(wr_data), .sts_rd(sts_rd), .sts_data(sts_data),
    .irq(irq), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .out_partial(out_partial), .out_pbits(out_pbits)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 60000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<=60000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int i);
    return 8'((f * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic wr(input bit bstart, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_burst_start = bstart; wr_addr = a; wr_data = d;
  endtask

  task automatic wr_idle();
    @(negedge clk);
    wr_en = 1'b0; wr_burst_start = 1'b0;
  endtask

  // R2: hi = count[11:4], lo = {count[3:0], bits, present}
  task automatic load_len(input int count, input int bits, input bit present);
    wr(1'b1, 8'h1D, 8'(count >> 4));
    wr(1'b0, 8'h00, {4'(count), 3'(bits), present});
    wr_idle();
  endtask

  task automatic push_pl(input int f, input int first, input int n, input bit fresh);
    for (int i = 0; i < n; i++)
      wr(fresh && (i == 0), 8'h1F, pat(f, first + i));
    wr_idle();
  endtask

  task automatic drain(input int f, input int total, input bit present, input int bits,
                       input int upto);
    int guard = 0;
    bit early_irq = 0;
    out_ready = 1'b1;
    while (bidx < upto && guard < 200) begin
      if (out_valid) begin
        if (total <= 4 && irq) early_irq = 1;
        chk(out_data == pat(f, bidx), "R5 byte order", out_data, pat(f, bidx));
        chk(out_last == (bidx == total - 1), "R6 last flag", out_last, bidx == total - 1);
        if (bidx == total - 1) begin
          chk(out_partial == present, "R6 partial", out_partial, present);
          chk(out_pbits == (present ? 3'(bits) : 3'd0), "R6 pbits", out_pbits,
              present ? bits : 0);
        end
        bidx++;
      end
      guard++;
      if (bidx < upto) @(negedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    if (total <= 4) chk(!early_irq, "R8 short frame irq only at end", early_irq, 0);
  endtask

  task automatic read_sts(input logic [7:0] exp, input string req);
    chk(sts_data == exp, req, sts_data, exp);
    chk(irq == (|exp[6:4]), "R10 irq from flags", irq, |exp[6:4]);
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
    chk(sts_data == 8'h00 && !irq, "R10 read clears", sts_data, 0);
  endtask

  task automatic run_frame(input int f, input int t);
    bit present = (t % 3 == 0);
    int count = t - (present ? 1 : 0);
    int bits = (t % 7) + 1;
    bidx = 0;
    load_len(count, bits, present);
    push_pl(f, 0, (t == 12) ? 13 : t, 1'b0);   // R3: 13th write dropped when full
    chk(sts_data == 8'h80 && !irq, "R4 start flag, no irq", sts_data, 8'h80);
    chk(out_valid && out_data == pat(f, 0), "R5 first byte offered", out_data, pat(f, 0));
    if (t == 7) begin
      load_len(255, 0, 1'b1);                  // R4: ignored while active
      chk(out_valid && !out_last, "R4 length locked", out_last, 0);
    end
    drain(f, t, present, bits, t);
    chk(!out_valid, "R7 frame closed", out_valid, 0);
    read_sts(8'hC0 | ((t >= 5) ? 8'h20 : 8'h00), "R7 R8 end status");
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_burst_start = 0; wr_addr = 0; wr_data = 0;
    sts_rd = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sts_data == 0 && !irq && !out_valid, "R10 reset state", sts_data, 0);

    // R4: zero length, payload write ignored
    load_len(0, 0, 1'b0);
    push_pl(99, 0, 2, 1'b1);
    chk(sts_data == 0 && !out_valid, "R4 zero length no start", sts_data, 0);

    // R1: writes outside the window do nothing
    wr(1'b1, 8'h10, 8'hFF); wr(1'b0, 8'h00, 8'hFF); wr(1'b0, 8'h00, 8'hFF);
    wr_idle();
    chk(sts_data == 0 && !out_valid, "R1 stray writes ignored", sts_data, 0);

    for (int t = 1; t <= 12; t++) run_frame(t, t);

    // R1/R2/R8: burst from 0x1C, count 20 with upper byte used, refill twice
    bidx = 0;
    wr(1'b1, 8'h1C, 8'hEE);
    wr(1'b0, 8'h00, 8'h01);
    wr(1'b0, 8'h00, 8'h40);
    wr_idle();
    push_pl(20, 0, 12, 1'b0);
    chk(sts_data == 8'h80, "R1 auto-increment reached data", sts_data, 8'h80);
    drain(20, 20, 1'b0, 0, 9);
    read_sts(8'hA0, "R8 refill at level 3");
    push_pl(20, 12, 8, 1'b1);
    drain(20, 20, 1'b0, 0, 20);
    read_sts(8'h60, "R2 R7 long frame end");

    // R9: underrun
    bidx = 0;
    load_len(6, 0, 1'b0);
    push_pl(30, 0, 2, 1'b0);
    read_sts(8'h80, "R4 start before underrun");
    out_ready = 1'b1;
    seen_last = 0;
    for (int k = 0; k < 4; k++) begin
      if (out_valid && out_last) seen_last = 1;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(!seen_last, "R9 no last on abort", seen_last, 0);
    chk(!out_valid, "R9 frame aborted", out_valid, 0);
    read_sts(8'h10, "R9 underrun flag");

    run_frame(31, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule